// File: doc/BRIEF.md
# Three-Wire Serial Configuration Port

This block is a serial slave that a host reaches over three wires: an active-low select, a serial clock and one data line that the host drives during writes and the block drives during reads. The wires are synchronised into the system clock domain, and the serial clock's rising edge is detected there. Each group of eight clocks forms a byte, sent most significant bit first. A byte whose top bit is 1 is an identifier. A byte whose top bit is 0 is data and carries seven payload bits.

An identifier in the window `ID_BASE` to `ID_BASE+NUM_REGS-1` points the port at one of the configuration registers. Data bytes then fill that register and the ones after it, one register per byte. The identifier `RD_ID` switches the port into read mode. Until select is released, the block shifts out bytes taken from the acquisition side and consumes no further commands. All register contents leave the block on one flat bus, where the rest of the chip can use them.

Top module: `serial_cfg_port`

## Requirements
- R1: After `rst_n` is asserted, every configuration register is 0 and `sdo_oe` is 0.
- R2: An identifier byte `0xF0+n` with n from 0 to 10, followed by a data byte `0ddddddd`, writes `ddddddd` into register n. Register n is `cfg[7n+6:7n]`.
- R3: Each further data byte after an identifier goes to the next register up. The register index advances by one per data byte.
- R4: The selected register index is kept while select is high. Data bytes in a later frame continue at the index where the previous frame stopped, with no new identifier.
- R5: After an identifier with top bit 1 that is neither `0x80` nor in `0xF0` to `0xFA`, data bytes change no register.
- R6: A data byte that would go past register 10 is discarded.
- R7: A data byte written to register 0 with bit 0 set clears every register to 0. This includes register 0 itself.
- R8: Identifier `0x80` enters read mode. `sdo_oe` goes to 1, and `sdo` presents `rd_byte` most significant bit first, one bit per serial clock. The block pulses `rd_next` once as it takes each byte. Bytes received while in read mode write no register.
- R9: Read mode ends when select goes high. `sdo_oe` then returns to 0, and bytes in the next frame are decoded as commands again.
- R10: The bit counter restarts whenever select goes high, so a partial byte is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock; data is taken on its rising edge |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data to host |
| sdo_oe | output | 1 | Drive enable for the shared data line |
| rd_byte | input | 8 | Byte offered by the acquisition side for readout |
| rd_next | output | 1 | One-cycle pulse: `rd_byte` has been taken |
| cfg | output | NUM_REGS*7 | All configuration registers, register n at bits 7n+6:7n |

## Verification
The bench builds the block with its default parameters: eleven registers, identifier window starting at 0xF0, read identifier 0x80 and a two-stage synchroniser. With these values both ends of the register window can be reached. An auto-increment run that starts at register 9 reaches the overflow case. The bench models the host with a serial clock six system cycles per phase, which is well above the synchroniser latency. This lets it sample `sdo` just before each rising edge and check multi-byte readout against its own model of the byte source.

// File: rtl/serial_cfg_port.sv
module serial_cfg_port #(
  parameter int NUM_REGS = 11,
  parameter int SYNC     = 2,
  parameter logic [7:0] ID_BASE = 8'hF0,
  parameter logic [7:0] RD_ID   = 8'h80
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_n,
  input  logic                  sclk,
  input  logic                  sdi,
  output logic                  sdo,
  output logic                  sdo_oe,
  input  logic [7:0]            rd_byte,
  output logic                  rd_next,
  output logic [NUM_REGS*7-1:0] cfg
);
  localparam int DW = 7;
  localparam int PW = $clog2(NUM_REGS);

  logic [SYNC-1:0] cs_sy, ck_sy, di_sy;
  logic            ck_d;
  logic            cs_s, di_s, rise;
  logic [6:0]      sh;
  logic [2:0]      bitcnt;
  logic [7:0]      full, off, txsh;
  logic            rd_mode, ptr_ok, id_hit;
  logic [PW-1:0]   ptr;
  logic [DW-1:0]   regs [NUM_REGS];

  assign cs_s   = cs_sy[SYNC-1];
  assign di_s   = di_sy[SYNC-1];
  assign rise   = ck_sy[SYNC-1] & ~ck_d;
  assign full   = {sh, di_s};
  assign off    = full - ID_BASE;
  assign id_hit = (full >= ID_BASE) && (off < 8'(NUM_REGS));
  assign sdo    = txsh[7];
  assign sdo_oe = rd_mode;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_out
    assign cfg[g*DW +: DW] = regs[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sy <= '1;
      ck_sy <= '1;
      di_sy <= '0;
      ck_d  <= 1'b1;
    end else begin
      cs_sy <= {cs_sy[SYNC-2:0], cs_n};
      ck_sy <= {ck_sy[SYNC-2:0], sclk};
      di_sy <= {di_sy[SYNC-2:0], sdi};
      ck_d  <= ck_sy[SYNC-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      bitcnt  <= '0;
      txsh    <= '0;
      rd_mode <= 1'b0;
      rd_next <= 1'b0;
      ptr_ok  <= 1'b0;
      ptr     <= '0;
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else begin
      rd_next <= 1'b0;
      if (cs_s) begin
        bitcnt  <= '0;
        rd_mode <= 1'b0;
      end else if (rise) begin
        bitcnt <= bitcnt + 3'd1;
        sh     <= full[6:0];
        if (rd_mode) begin
          if (bitcnt == 3'd7) begin
            txsh    <= rd_byte;
            rd_next <= 1'b1;
          end else begin
            txsh <= {txsh[6:0], 1'b0};
          end
        end else if (bitcnt == 3'd7) begin
          if (full[7]) begin
            if (full == RD_ID) begin
              rd_mode <= 1'b1;
              txsh    <= rd_byte;
              rd_next <= 1'b1;
            end
            ptr_ok <= id_hit;
            if (id_hit) ptr <= PW'(off);
          end else if (ptr_ok) begin
            if (ptr == '0 && full[0])
              for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
            else
              regs[ptr] <= full[6:0];
            ptr <= ptr + 1'b1;
            if (ptr == PW'(NUM_REGS - 1)) ptr_ok <= 1'b0;
          end
        end
      end
    end
  end
endmodule

module serial_cfg_port_chk #(
  parameter int NUM_REGS = 11,
  parameter int PW = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cs_s,
  input logic                  sdo_oe,
  input logic                  rd_next,
  input logic                  ptr_ok,
  input logic [PW-1:0]         ptr,
  input logic [NUM_REGS*7-1:0] cfg
);
  p_oe_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !sdo_oe);
  p_deselect_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> $stable(cfg));
  p_read_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |=> $stable(cfg));
  p_take_in_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_next |-> sdo_oe);
  p_take_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_next |=> !rd_next);
  p_ptr_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_ok |-> (ptr < PW'(NUM_REGS)));
endmodule

bind serial_cfg_port serial_cfg_port_chk #(.NUM_REGS(NUM_REGS), .PW($clog2(NUM_REGS))) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sdo_oe(sdo_oe),
  .rd_next(rd_next), .ptr_ok(ptr_ok), .ptr(ptr), .cfg(cfg));

// File: tb/serial_cfg_port_test.sv
module serial_cfg_port_test;
  localparam int NR = 11;

  logic clk = 0, rst_n = 0, cs_n = 1, sclk = 1, sdi = 0;
  logic sdo, sdo_oe, rd_next;
  logic [7:0] rd_byte;
  logic [NR*7-1:0] cfg;
  int checks = 0, fails = 0, src_idx = 0;
  bit done = 0;

  always #5 clk = ~clk;

  serial_cfg_port uut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .rd_byte(rd_byte), .rd_next(rd_next), .cfg(cfg));

  function automatic logic [7:0] src(input int k);
    return 8'hA5 ^ 8'(k * 59);
  endfunction
  assign rd_byte = src(src_idx);
  always @(posedge clk) if (rd_next) src_idx <= src_idx + 1;

  localparam logic [15:0] VEC [8] = '{16'hF12A, 16'hF57F, 16'hFA55, 16'hF300,
                                      16'hF241, 16'hF91C, 16'hF004, 16'hF733};

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      sdi = tx[i]; sclk = 0;
      repeat (6) @(negedge clk);
      rx[i] = sdo; sclk = 1;
      repeat (6) @(negedge clk);
    end
  endtask

  task automatic sel;   cs_n = 0; repeat (4) @(negedge clk); endtask
  task automatic desel; cs_n = 1; repeat (8) @(negedge clk); endtask

  task automatic wr2(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r;
    sel; xfer(a, r); xfer(b, r); desel;
  endtask

  function automatic logic [6:0] rg(input int n);
    return cfg[n*7 +: 7];
  endfunction

  initial begin
    logic [7:0] r;
    logic [NR*7-1:0] snap;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(cfg == '0, "R1 cfg", cfg, 0);
    check(sdo_oe == 0, "R1 oe", sdo_oe, 0);

    for (int v = 0; v < 8; v++) begin
      wr2(VEC[v][15:8], VEC[v][7:0]);
      check(rg(VEC[v][15:8] - 8'hF0) == VEC[v][6:0], "R2 write", rg(VEC[v][15:8] - 8'hF0), VEC[v][6:0]);
    end

    sel; xfer(8'hF4, r); xfer(8'h11, r); xfer(8'h22, r); xfer(8'h33, r); desel;
    check(rg(4) == 7'h11, "R3 reg4", rg(4), 7'h11);
    check(rg(5) == 7'h22, "R3 reg5", rg(5), 7'h22);
    check(rg(6) == 7'h33, "R3 reg6", rg(6), 7'h33);

    sel; xfer(8'h44, r); desel;
    check(rg(7) == 7'h44, "R4 retained", rg(7), 7'h44);

    snap = cfg;
    wr2(8'hC3, 8'h5A);
    check(cfg == snap, "R5 unknown id", cfg, snap);

    sel; xfer(8'hF9, r); xfer(8'h01, r); xfer(8'h02, r); xfer(8'h03, r); desel;
    check(rg(9) == 7'h01, "R6 reg9", rg(9), 7'h01);
    check(rg(10) == 7'h02, "R6 reg10", rg(10), 7'h02);
    snap = cfg;
    sel; xfer(8'h7E, r); desel;
    check(cfg == snap, "R6 overflow", cfg, snap);

    sel;
    for (int i = 0; i < 3; i++) begin
      sdi = 1; sclk = 0; repeat (6) @(negedge clk); sclk = 1; repeat (6) @(negedge clk);
    end
    desel;
    wr2(8'hF8, 8'h6C);
    check(rg(8) == 7'h6C, "R10 realign", rg(8), 7'h6C);

    snap = cfg;
    base = src_idx;
    sel; xfer(8'h80, r);
    check(sdo_oe == 1, "R8 oe", sdo_oe, 1);
    xfer(8'hF1, r);
    check(r == src(base), "R8 byte0", r, src(base));
    xfer(8'h00, r);
    check(r == src(base + 1), "R8 byte1", r, src(base + 1));
    xfer(8'h80, r);
    check(r == src(base + 2), "R8 byte2", r, src(base + 2));
    check(cfg == snap, "R8 no write", cfg, snap);
    desel;
    check(sdo_oe == 0, "R9 oe off", sdo_oe, 0);
    wr2(8'hF1, 8'h13);
    check(rg(1) == 7'h13, "R9 cmd again", rg(1), 7'h13);

    wr2(8'hF0, 8'h01);
    check(cfg == '0, "R7 soft reset", cfg, 0);

    wr2(8'hF3, 8'h2B);
    rst_n = 0; repeat (2) @(negedge clk); rst_n = 1; repeat (2) @(negedge clk);
    check(cfg == '0, "R1 hard reset", cfg, 0);

    done = 1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule